// File: doc/BRIEF.md
# Retransmit-Capable FIFO Queue

This block is a first-in first-out queue of 9-bit words with a write port and a read port. Each port has its own active-low strobe, and neither port takes an address. The queue tracks its write and read positions internally. It reports three status flags: empty, half-full and full. The target configuration holds 8192 words. The depth is the parameter `DEPTH`, a power of two, and its default is 1024 to keep elaboration light. Every flag threshold is derived from `DEPTH`.

A retransmit strobe rewinds the read side to physical location zero and leaves the write side alone. Everything stored from location zero up to the current write position can then be read out again, as many times as needed. This is only meaningful while neither position has gone past location zero since the last reset. The design gives no promise about retransmit once that has happened.

All strobes are sampled on the rising edge of one clock. A strobe held low counts as one operation per cycle. Read data is registered and appears the cycle after the accepted read.

Top module: `fifo_rt`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted at the write port. A read accepted at edge N places its word on `dout` after edge N.
- R2: While `rst_n` is low, both positions are cleared, `empty` is 1, `half_full` and `full` are 0, and `dout` is 0.
- R3: A write strobe while `full` is 1 is ignored. No word is stored, the occupancy does not change, and later reads return only the earlier words.
- R4: A read strobe while `empty` is 1 is ignored. `dout` keeps its value and the read position does not move.
- R5: When reading and writing in the same cycle with the queue neither empty nor full, both operations are honoured and the occupancy stays the same.
- R6: `empty` is 1 exactly when the occupancy is 0.
- R7: `half_full` is 1 exactly when the occupancy is at least `DEPTH/2`.
- R8: `full` is 1 exactly when the occupancy equals `DEPTH`. The occupancy never exceeds `DEPTH`.
- R9: A low `rt_n` sets the read position to location 0 and leaves the write position unchanged. The occupancy becomes the number of words written since reset, and subsequent reads replay from the first word written.
- R10: Retransmit can be repeated any number of times. Each one replays the same sequence.
- R11: In a cycle where `rt_n` is low, the read and write strobes are ignored.
- R12: `dout` holds its value in every cycle in which no read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low retransmit (rewind read side to location 0) |
| din | input | 9 | Word to store |
| dout | output | 9 | Registered word from the last accepted read |
| empty | output | 1 | Occupancy is zero |
| half_full | output | 1 | Occupancy is at least half the depth |
| full | output | 1 | Occupancy equals the depth |

## Verification
The assertions assume retransmit is used only before either position wraps past location zero. They also assume every input is stable around the rising edge. The bench drives all inputs on the falling edge. It issues retransmit only in a phase that follows a fresh reset and writes fewer than `DEPTH` words. Its long mixed read/write phase, which wraps the positions, never asserts retransmit.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } fifo_flags_t;

  // Occupancy from two wrap-extended positions, modulo the position span.
  function automatic int unsigned occupancy(input int unsigned wp,
                                            input int unsigned rp,
                                            input int unsigned span);
    return (wp + span - rp) % span;
  endfunction

  function automatic logic reached_half(input int unsigned cnt,
                                        input int unsigned depth);
    return cnt >= (depth / 2);
  endfunction

  function automatic logic reached_top(input int unsigned cnt,
                                       input int unsigned depth);
    return cnt == depth;
  endfunction

endpackage

// File: rtl/fifo_rt_ctrl.sv
module fifo_rt_ctrl #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  input  logic          full,
  input  logic          empty,
  output logic          wr_go,
  output logic          rd_go,
  output logic          rt_go,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr
);

  // Retransmit takes the cycle: both data strobes are dropped.
  assign rt_go = !rt_n;
  assign wr_go = !wr_n && rt_n && !full;
  assign rd_go = !rd_n && rt_n && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (rt_go) begin
      rd_ptr <= '0;
    end else begin
      if (wr_go) wr_ptr <= wr_ptr + PW'(1);
      if (rd_go) rd_ptr <= rd_ptr + PW'(1);
    end
  end

  // R9, R11: rewind lands on location 0, write side untouched
  assert_rt_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rd_ptr == '0) && (wr_ptr == $past(wr_ptr)));

  // R1: read side advances by at most one word per cycle
  assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rt_n |=> (rd_ptr == $past(rd_ptr)) || (rd_ptr == $past(rd_ptr) + PW'(1)));

endmodule

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] din,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (re) dout <= mem[raddr];
  end

  // R12: output register only moves on an accepted read
  assert_dout_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(dout));

endmodule

// File: rtl/fifo_rt_status.sv
module fifo_rt_status #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic                     wr_ptr_valid,
  input  logic [PW-1:0]            wr_ptr,
  input  logic [PW-1:0]            rd_ptr,
  output logic [PW-1:0]            count,
  output fifo_rt_pkg::fifo_flags_t flags
);

  localparam int unsigned SPAN = 2 * DEPTH;

  int unsigned occ;

  always_comb begin
    occ = fifo_rt_pkg::occupancy(int'(wr_ptr), int'(rd_ptr), SPAN);
    count = PW'(occ);
    flags.empty = (occ == 0) && wr_ptr_valid;
    flags.half  = fifo_rt_pkg::reached_half(occ, DEPTH);
    flags.full  = fifo_rt_pkg::reached_top(occ, DEPTH);
  end

endmodule

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             half_full,
  output logic             full
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  // Named internal events for the assertions.
  logic          wr_go;
  logic          rd_go;
  logic          rt_go;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] count;
  fifo_rt_pkg::fifo_flags_t flags;

  fifo_rt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_n   (wr_n),
    .rd_n   (rd_n),
    .rt_n   (rt_n),
    .full   (flags.full),
    .empty  (flags.empty),
    .wr_go  (wr_go),
    .rd_go  (rd_go),
    .rt_go  (rt_go),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr)
  );

  fifo_rt_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_go),
    .waddr (wr_ptr[AW-1:0]),
    .din   (din),
    .re    (rd_go),
    .raddr (rd_ptr[AW-1:0]),
    .dout  (dout)
  );

  fifo_rt_status #(.DEPTH(DEPTH)) u_status (
    .wr_ptr_valid (1'b1),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .count        (count),
    .flags        (flags)
  );

  assign empty     = flags.empty;
  assign half_full = flags.half;
  assign full      = flags.full;

  // R3: a write strobe alone on a full queue leaves it full, write side still
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_n && rd_n && rt_n) |=> full && (wr_ptr == $past(wr_ptr)));

  // R4: a read strobe alone on an empty queue changes nothing visible
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rd_n && wr_n && rt_n) |=> empty && $stable(dout));

  // R5: paired read and write in the middle keep the occupancy
  assert_pair_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !rd_n && rt_n && !empty && !full) |=> (count == $past(count)));

  // R8: occupancy bounded by the depth
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);

  // R6, R7: flags are mutually consistent
  assert_flag_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full |-> half_full) and (empty |-> !half_full));

  // R11: retransmit cycle stores nothing
  assert_rt_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (wr_ptr == $past(wr_ptr)));

endmodule

// File: tb/fifo_rt_test.sv
module fifo_rt_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int WIDTH = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1;
  logic rd_n = 1'b1;
  logic rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic empty, half_full, full;

  fifo_rt #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .empty(empty), .half_full(half_full), .full(full)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0;
  int misses = 0;

  // Reference model: every word written since reset, and a read index.
  logic [WIDTH-1:0] hist[$];
  int rd_i = 0;
  logic [WIDTH-1:0] exp_dout = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    int cnt;
    cnt = hist.size() - rd_i;
    chk(dout === exp_dout, tag, int'(dout), int'(exp_dout));
    chk(empty === (cnt == 0), "R6", int'(empty), int'(cnt == 0));
    chk(half_full === (cnt >= DEPTH / 2), "R7", int'(half_full), int'(cnt >= DEPTH / 2));
    chk(full === (cnt == DEPTH), "R8", int'(full), int'(cnt == DEPTH));
  endtask

  task automatic step(input logic w, input logic r, input logic t,
                      input logic [WIDTH-1:0] d, input string tag);
    int cnt;
    @(negedge clk);
    wr_n = w; rd_n = r; rt_n = t; din = d;
    cnt = hist.size() - rd_i;
    if (!t) begin
      rd_i = 0;
    end else begin
      if (!r && cnt > 0) begin
        exp_dout = hist[rd_i];
        rd_i++;
      end
      if (!w && cnt < DEPTH) hist.push_back(d);
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    hist.delete();
    rd_i = 0;
    exp_dout = '0;
    @(posedge clk);
    #1;
    compare("R2");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    misses++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R2");
    @(negedge clk);
    rst_n = 1'b1;

    // R1: simple ordering
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 9'(10 + i), "R1");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1, '0, "R1");

    // R4: reads on an empty queue, then idle for R12
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, '0, "R4");
    step(1'b1, 1'b1, 1'b1, '0, "R12");

    // R7, R8: fill past half up to full, then R3 writes while full
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, 1'b1, 9'(100 + i), "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 9'(400 + i), "R3");
    // R5 boundary: paired strobes on full -> read only
    step(1'b0, 1'b0, 1'b1, 9'(450), "R5");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b1, '0, "R3");

    // R5: paired strobes on empty -> write only, then mid-level pairs
    step(1'b0, 1'b0, 1'b1, 9'(300), "R5");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 9'(310 + i), "R5");
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1, 9'(320 + i), "R5");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, '0, "R5");

    // R9, R10, R11: replay from location 0 after a fresh reset
    do_reset();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b1, 9'(200 + i), "R9");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1, '0, "R9");
    step(1'b1, 1'b1, 1'b0, '0, "R9");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, '0, "R9");
    step(1'b1, 1'b0, 1'b1, '0, "R4");
    for (int k = 0; k < 2; k++) begin
      step(1'b0, 1'b0, 1'b0, 9'(499), "R11");
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '0, "R10");
    end
    step(1'b1, 1'b1, 1'b0, '0, "R10");
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b1, '0, "R10");

    // R1: long mixed traffic with wrap-around, no retransmit
    do_reset();
    for (int i = 0; i < 600; i++) begin
      int bias;
      logic w, r;
      bias = ((i / 100) % 2 == 0) ? 70 : 30;
      w = !(($urandom % 100) < bias);
      r = !(($urandom % 100) < (100 - bias));
      step(w, r, 1'b1, 9'($urandom % 512), "R1");
    end
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, 1'b1, '0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule